// File: doc/BRIEF.md
# Sequential 4x4 Matrix Inverter (Gauss-Jordan)

This block inverts a 4x4 signed fixed-point matrix. A one-cycle start pulse copies the sixteen input entries into a working array of four rows, each eight entries wide. The left half of each row holds the matrix row and the right half holds the matching row of an identity matrix. The block then visits the diagonal positions in order. For each pivot it forms the reciprocal of the diagonal entry with a sequential restoring divider. It scales the pivot row by that reciprocal, then clears the pivot column in the other three rows. Each clearing subtracts a multiple of the pivot row.

One eight-lane unit does every row update. The unit computes `a - b*k` with rounding, and scaling uses it with `a` forced to zero and `k` negated. When the last pivot is done, the right half of the array holds the inverse. The block then raises `done`. Rows are never exchanged. If a diagonal entry is exactly zero when its turn comes, the block stops at once and raises `singular` together with `done`.

Top module: `matinv_top`

## Requirements
- R1: While reset is asserted and after its release, `done` and `singular` are low and every entry of `resultOut` is zero.
- R2: A `start` pulse accepted while idle brings `done` and `singular` low on the same clock edge that samples it.
- R3: Entries are signed two's complement with 16 integer bits and 16 fraction bits. Entry (row r, column c) sits at bits `(r*4+c)*32` to `(r*4+c)*32+31` of both `matIn` and `resultOut`. For a well-conditioned matrix whose diagonal entries stay nonzero during elimination without row exchanges, every output entry lies within 1/1024 of the true inverse.
- R4: For a non-singular input, `done` is first seen high after the 159th rising edge, counting the edge that sampled `start` as the first. In general this is 3 + 4*(2*FRAC_W+7) edges.
- R5: If the diagonal entry of pivot p (p = 0..3) is zero when that pivot is reached, `singular` and `done` both rise after edge 3 + 39*p.
- R6: `singular` is never high while `done` is low.
- R7: A `start` pulse that arrives while a computation is running has no effect. The running computation finishes with unchanged latency and the result of the originally loaded matrix, even if `matIn` has changed.
- R8: Once `done` is high, it and `resultOut` hold their values until the next accepted `start`.
- R9: When every inverse entry is exactly representable and each reciprocal is exact, the result is bit-exact. This covers the identity matrix and a diagonal matrix with power-of-two entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to load `matIn` and begin inversion |
| matIn | input | 512 | Sixteen Q16.16 input entries, row-major |
| resultOut | output | 512 | Sixteen Q16.16 inverse entries, row-major |
| done | output | 1 | High once the inversion or the singular stop has finished |
| singular | output | 1 | High when a zero pivot stopped the run |

## Verification
The assertions check, on every cycle, the flag rules. These are that `singular` only appears with `done`, that an accepted start clears both flags, that a start during a run neither aborts it nor restarts it, and that the result stays frozen while `done` holds. Numerical behaviour can only be shown by the bench scenarios. That covers the accuracy of the inverse against a real-valued elimination, bit-exact cases, the exact cycle count, and detection of zero pivots in the first and second columns. The bench also drives a second start with different data mid-run and confirms that the first matrix's inverse still appears on time.

// File: rtl/matinv_pkg.sv
package matinv_pkg;
  localparam int DIM   = 4;
  localparam int IDX_W = $clog2(DIM);
  localparam int COLS  = 2 * DIM;

  typedef struct packed {
    logic             load;
    logic             divStart;
    logic             scale;
    logic             elim;
    logic [IDX_W-1:0] pivot;
    logic [IDX_W-1:0] row;
  } ctrlStrobes_t;
endpackage

// File: rtl/matinv_dp.sv
module matinv_dp
  import matinv_pkg::*;
#(
  parameter int W      = 32,
  parameter int FRAC_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           stb,
  input  logic [DIM*DIM*W-1:0]   matIn,
  output logic [DIM*DIM*W-1:0]   resultOut,
  output logic                   pivotZero,
  output logic                   divBusy
);
  localparam int DIVW  = 2 * FRAC_W + 1;
  localparam int CNT_W = $clog2(DIVW + 1);
  localparam logic [DIVW-1:0] RECIP_MAX = DIVW'((64'(1) << (W - 1)) - 1);
  localparam logic [2*W-1:0]  ROUND_HALF = (2*W)'(1) << (FRAC_W - 1);

  logic signed [W-1:0] arr [DIM][COLS];

  // divider state
  logic [DIVW-1:0]  quo;
  logic [W:0]       rem;
  logic [W-1:0]     divisor;
  logic             negPivot;
  logic [CNT_W-1:0] cnt;

  logic signed [W-1:0] pivotVal;
  logic [W:0]          remShift;
  logic                fits;
  logic [W-1:0]        recipMag;
  logic signed [W-1:0] recip;

  logic [IDX_W-1:0]    target;
  logic signed [W-1:0] laneA   [COLS];
  logic signed [W-1:0] laneB   [COLS];
  logic signed [W-1:0] laneOut [COLS];
  logic signed [W-1:0] kVal;

  assign pivotVal  = arr[stb.pivot][stb.pivot];
  assign pivotZero = (pivotVal == '0);
  assign divBusy   = (cnt != '0);

  always_comb begin
    remShift = {rem[W-1:0], quo[DIVW-1]};
    fits     = (remShift >= {1'b0, divisor});
    recipMag = (quo > RECIP_MAX) ? RECIP_MAX[W-1:0] : quo[W-1:0];
    recip    = negPivot ? -$signed(recipMag) : $signed(recipMag);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quo      <= '0;
      rem      <= '0;
      divisor  <= '0;
      negPivot <= 1'b0;
      cnt      <= '0;
    end else if (stb.divStart) begin
      quo      <= DIVW'(1) << (2 * FRAC_W);
      rem      <= '0;
      divisor  <= pivotVal[W-1] ? W'(-pivotVal) : W'(pivotVal);
      negPivot <= pivotVal[W-1];
      cnt      <= CNT_W'(DIVW);
    end else if (divBusy) begin
      rem <= fits ? (remShift - {1'b0, divisor}) : remShift;
      quo <= {quo[DIVW-2:0], fits};
      cnt <= cnt - 1'b1;
    end
  end

  // shared row unit: out = a - round(b * k)
  assign target = stb.scale ? stb.pivot : stb.row;
  assign kVal   = stb.scale ? -recip : arr[stb.row][stb.pivot];

  for (genvar c = 0; c < COLS; c++) begin : g_lane
    logic signed [2*W-1:0] prod;
    logic signed [2*W-1:0] rounded;
    assign laneA[c]   = stb.scale ? '0 : arr[target][c];
    assign laneB[c]   = arr[stb.pivot][c];
    assign prod       = laneB[c] * kVal;
    assign rounded    = (prod + $signed(ROUND_HALF)) >>> FRAC_W;
    assign laneOut[c] = laneA[c] - rounded[W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < COLS; c++)
          arr[r][c] <= '0;
    end else if (stb.load) begin
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++) begin
          arr[r][c]       <= matIn[(r*DIM+c)*W +: W];
          arr[r][DIM + c] <= (r == c) ? (W'(1) << FRAC_W) : '0;
        end
    end else if (stb.scale || stb.elim) begin
      for (int c = 0; c < COLS; c++)
        arr[target][c] <= laneOut[c];
    end
  end

  for (genvar r = 0; r < DIM; r++) begin : g_outRow
    for (genvar c = 0; c < DIM; c++) begin : g_outCol
      assign resultOut[(r*DIM+c)*W +: W] = arr[r][DIM + c];
    end
  end
endmodule

// File: rtl/matinv_ctrl.sv
module matinv_ctrl
  import matinv_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         pivotZero,
  input  logic         divBusy,
  output ctrlStrobes_t stb,
  output logic         done,
  output logic         singular,
  output logic         busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_CHECK, S_DIVWAIT, S_SCALE, S_ELIM, S_FINISH
  } state_t;

  state_t           state;
  logic [IDX_W-1:0] pivot;
  logic [IDX_W-1:0] elimCnt;

  always_comb begin
    stb          = '0;
    stb.pivot    = pivot;
    stb.row      = (elimCnt >= pivot) ? IDX_W'(elimCnt + 1'b1) : elimCnt;
    stb.load     = (state == S_LOAD);
    stb.divStart = (state == S_CHECK) && !pivotZero;
    stb.scale    = (state == S_SCALE);
    stb.elim     = (state == S_ELIM);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      pivot    <= '0;
      elimCnt  <= '0;
      done     <= 1'b0;
      singular <= 1'b0;
      busy     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done     <= 1'b0;
          singular <= 1'b0;
          busy     <= 1'b1;
          state    <= S_LOAD;
        end
        S_LOAD: begin
          pivot <= '0;
          state <= S_CHECK;
        end
        S_CHECK: if (pivotZero) begin
          singular <= 1'b1;
          done     <= 1'b1;
          busy     <= 1'b0;
          state    <= S_IDLE;
        end else begin
          state <= S_DIVWAIT;
        end
        S_DIVWAIT: if (!divBusy) state <= S_SCALE;
        S_SCALE: begin
          elimCnt <= '0;
          state   <= S_ELIM;
        end
        S_ELIM: if (elimCnt == IDX_W'(DIM - 2)) begin
          if (pivot == IDX_W'(DIM - 1)) begin
            state <= S_FINISH;
          end else begin
            pivot <= pivot + 1'b1;
            state <= S_CHECK;
          end
        end else begin
          elimCnt <= elimCnt + 1'b1;
        end
        S_FINISH: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/matinv_top.sv
module matinv_top
  import matinv_pkg::*;
#(
  parameter int W      = 32,
  parameter int FRAC_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [DIM*DIM*W-1:0] matIn,
  output logic [DIM*DIM*W-1:0] resultOut,
  output logic                 done,
  output logic                 singular
);
  ctrlStrobes_t stb;
  logic         pivotZero;
  logic         divBusy;
  logic         busy;

  matinv_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pivotZero(pivotZero),
    .divBusy(divBusy), .stb(stb), .done(done), .singular(singular), .busy(busy)
  );

  matinv_dp #(.W(W), .FRAC_W(FRAC_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .matIn(matIn),
    .resultOut(resultOut), .pivotZero(pivotZero), .divBusy(divBusy)
  );
endmodule

// File: rtl/matinv_chk.sv
module matinv_chk #(
  parameter int OUT_W = 512
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             singular,
  input logic [OUT_W-1:0] resultOut
);
  p_singular_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    singular |-> done);

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (!done && !singular && busy));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy) |=> (busy || done));

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(resultOut)));

  p_done_after_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));
endmodule

bind matinv_top matinv_chk #(.OUT_W($bits(resultOut))) i_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .done(done), .singular(singular), .resultOut(resultOut)
);

// File: tb/test_matinv_top.sv
module test_matinv_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int FRAC_W = 16;
  localparam int N = 4;
  localparam int PER_PIVOT = 2 * FRAC_W + 7;
  localparam int LATENCY = 3 + N * PER_PIVOT;
  localparam int WATCHDOG = 2000;
  localparam real TOL = 1.0 / 1024.0;
  localparam int NV = 5;
  // entries in quarters (value = q / 4)
  localparam int VEC [NV][16] = '{
    '{4,0,0,0, 0,4,0,0, 0,0,4,0, 0,0,0,4},
    '{8,0,0,0, 0,16,0,0, 0,0,2,0, 0,0,0,-4},
    '{4,8,0,0, 0,4,12,0, 0,0,4,16, 0,0,0,4},
    '{16,4,0,0, 4,12,4,0, 0,4,8,4, 0,0,4,20},
    '{12,-4,0,4, 4,12,-4,0, 0,4,16,8, -4,0,4,12}
  };
  localparam bit EXACT [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [N*N*W-1:0] matIn = '0;
  logic [N*N*W-1:0] resultOut;
  logic done, singular;

  int checks = 0;
  int fails = 0;
  real refInv [16];
  int edges;

  always #(CLK_PERIOD/2) clk = ~clk;

  matinv_top i_matinv_top (
    .clk(clk), .rstN(rstN), .start(start), .matIn(matIn),
    .resultOut(resultOut), .done(done), .singular(singular)
  );

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic logic [N*N*W-1:0] packMat(input int q [16]);
    logic [N*N*W-1:0] v = '0;
    for (int k = 0; k < 16; k++) v[k*W +: W] = W'(q[k] * 16384);
    return v;
  endfunction

  function automatic real entryOf(input int k);
    logic signed [W-1:0] e = resultOut[k*W +: W];
    return $itor(e) / 65536.0;
  endfunction

  task automatic computeRef(input int q [16]);
    real m [4][8];
    real f;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++)
        m[r][c] = (c < 4) ? q[r*4+c] / 4.0 : ((c - 4 == r) ? 1.0 : 0.0);
    for (int p = 0; p < 4; p++) begin
      f = m[p][p];
      for (int c = 0; c < 8; c++) m[p][c] = m[p][c] / f;
      for (int r = 0; r < 4; r++)
        if (r != p) begin
          f = m[r][p];
          for (int c = 0; c < 8; c++) m[r][c] = m[r][c] - f * m[p][c];
        end
    end
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) refInv[r*4+c] = m[r][c+4];
  endtask

  // pulse start at a negedge, then count edges until done is seen high
  task automatic pulseStart(input int q [16]);
    @(negedge clk);
    matIn = packMat(q);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    check(!done && !singular, "R2", $sformatf("flags after start done=%0b singular=%0b expected 0 0", done, singular));
  endtask

  task automatic waitDone();
    while (!done && edges <= WATCHDOG) begin
      @(negedge clk);
      edges++;
    end
    if (!done) check(1'b0, "R4", $sformatf("watchdog expired after %0d edges, expected done", edges));
  endtask

  task automatic checkResult(input int v, input string req, input bit exact);
    for (int k = 0; k < 16; k++) begin
      real a = entryOf(k);
      real d = a - refInv[k];
      if (d < 0.0) d = -d;
      if (exact)
        check(a == refInv[k], req, $sformatf("vec %0d entry %0d actual %f expected %f exactly", v, k, a, refInv[k]));
      else
        check(d <= TOL, req, $sformatf("vec %0d entry %0d actual %f expected %f", v, k, a, refInv[k]));
    end
  endtask

  initial begin
    int vq [16];
    logic [N*N*W-1:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!done && !singular && resultOut == '0, "R1", $sformatf("in reset done=%0b singular=%0b result nonzero=%0b expected 0 0 0", done, singular, resultOut != '0));
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !singular && resultOut == '0, "R1", $sformatf("after reset done=%0b singular=%0b expected 0 0", done, singular));

    // table of vectors: R3 accuracy, R4 latency, R9 exact cases
    for (int v = 0; v < NV; v++) begin
      vq = VEC[v];
      computeRef(vq);
      pulseStart(vq);
      waitDone();
      check(edges == LATENCY, "R4", $sformatf("vec %0d latency %0d expected %0d", v, edges, LATENCY));
      check(!singular, "R3", $sformatf("vec %0d singular=%0b expected 0", v, singular));
      checkResult(v, EXACT[v] ? "R9" : "R3", EXACT[v]);
    end

    // R8: result and done hold while idle
    held = resultOut;
    repeat (7) @(negedge clk);
    check(done && resultOut == held, "R8", $sformatf("hold done=%0b changed=%0b expected 1 0", done, resultOut != held));

    // R5: zero pivot in column 0
    vq = '{0,0,0,0, 0,0,0,0, 0,0,0,0, 0,0,0,0};
    pulseStart(vq);
    waitDone();
    check(singular && edges == 3, "R5", $sformatf("pivot0 singular=%0b edges=%0d expected 1 3", singular, edges));

    // R5: zero pivot in column 1 after elimination
    vq = '{4,4,0,0, 4,4,0,0, 0,0,4,0, 0,0,0,4};
    pulseStart(vq);
    waitDone();
    check(singular && edges == 3 + PER_PIVOT, "R5", $sformatf("pivot1 singular=%0b edges=%0d expected 1 %0d", singular, edges, 3 + PER_PIVOT));

    // R2: a new start after a singular run clears singular, then inverts
    vq = VEC[3];
    computeRef(vq);
    pulseStart(vq);
    // R7: second start with different data during the run is ignored
    repeat (20) begin @(negedge clk); edges++; end
    matIn = packMat(VEC[4]);
    start = 1'b1;
    @(negedge clk); edges++;
    start = 1'b0;
    waitDone();
    check(edges == LATENCY && !singular, "R7", $sformatf("latency %0d singular=%0b expected %0d 0", edges, singular, LATENCY));
    checkResult(3, "R7", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule